// File: doc/BRIEF.md
# Serial Channel Command Executor

This block takes one-shot commands from a host for a single serial channel and turns them into single-cycle strobes. The strobes clear or abort pieces of the channel's receive and transmit state. The host writes one of two byte-wide command registers through a small write port.

The first register holds three clear requests: clear receiver, clear transmitter and clear general timer. The second register holds the transmit specials: frame abort, append-complete, send-special and a special-character select. Both registers read back what was accepted for exactly one cycle and then fall back to zero once the command has been acted on.

The surrounding FIFOs, buffer descriptors, status registers, timer and line driver are reduced to small stub state inside the block. Their effect can therefore be observed at the ports. A protocol-mode input decides which commands apply: clearing the transmitter only works in asynchronous mode, and aborting a frame only works in synchronous (HDLC) mode.

Top module: `chanCmdExec`

## Requirements
- R1: After reset both command readbacks are 0x00, all strobes are low, FIFO levels, status, ownership flags, combined buffer status and timer are zero, the receiver is hunting (rxHunting=1) and txLine is 1.
- R2: A write with cmdSel=0 stores cmdData bits 5 (clear timer), 4 (clear receiver) and 3 (clear transmitter) and returns 0 in every other bit. A write with cmdSel=1 stores bits 6 (abort), 5 (append-complete), 3 (send-special) and 2:0 (character select), and returns 0 in bits 7 and 4. The stored value reads back in the cycle after the write and is 0x00 one cycle later unless a new write arrives.
- R3: Each accepted command bit raises its strobe for exactly the one cycle after the write. Several bits written together raise all their strobes in that same cycle.
- R4: A clear-receiver strobe sets rxLevel to 0 and zeroes rxStatus bits above bit 0. Bit 0 is the receiver enable and keeps its value.
- R5: A clear-receiver strobe zeroes both receive ownership flags and bufStatus bits 1:0.
- R6: A clear-receiver strobe in synchronous mode (asyncMode=0) sets rxHunting. In asynchronous mode rxHunting is left unchanged, and rxSyncFound clears it.
- R7: In asynchronous mode a clear-transmitter strobe sets txLevel to 0, zeroes txStatus above enable bit 0, zeroes both transmit ownership flags and zeroes bufStatus bits 3:2.
- R8: A clear-transmitter command written while asyncMode=0 raises no strobe and leaves every transmit output unchanged.
- R9: A clear-timer strobe returns timer2Val to 0. Otherwise the timer counts timerTick and wraps.
- R10: An abort in synchronous mode drives txLine high for ABORT_ONES consecutive cycles (txAborting high over the same cycles), then emits flags 0x7E least significant bit first. An abort written in asynchronous mode raises no strobe and txLine stays 1.
- R11: An abort with dmaMode=1 drops the queued transmit entries up to and including the first end-of-frame entry, or all entries if none is queued. Any entries that remain count as one open frame. With dmaMode=0 the level is unchanged.
- R12: rxPush only adds an entry while at least one receive ownership flag is set. The host sets the flags through rxBufGive (bit 0 buffer A, bit 1 buffer B).
- R13: Receive and transmit levels saturate at DEPTH, and pushes into a full FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write enable |
| cmdSel | input | 1 | 0 = channel clear register, 1 = transmit special register |
| cmdData | input | 8 | Command write data |
| asyncMode | input | 1 | 1 = asynchronous protocol, 0 = synchronous/HDLC |
| dmaMode | input | 1 | Transmit data is fed by DMA |
| rxPush | input | 1 | Stub: receive FIFO push |
| rxStatSet | input | STAT_W | Stub: receive status bits to set |
| rxBufGive | input | 2 | Host returns receive buffers A/B |
| rxSyncFound | input | 1 | Stub: receiver found sync |
| txPush | input | 1 | Stub: transmit FIFO push |
| txPushEof | input | 1 | Pushed entry ends a frame |
| txStatSet | input | STAT_W | Stub: transmit status bits to set |
| txBufGive | input | 2 | Host returns transmit buffers A/B |
| bufStatSet | input | 4 | Stub: combined buffer status bits to set |
| timerTick | input | 1 | General timer increment |
| chanCmdRd | output | 8 | Channel clear register readback |
| txCmdRd | output | 8 | Transmit special register readback |
| clrRxPulse | output | 1 | Clear-receiver strobe |
| clrTxPulse | output | 1 | Clear-transmitter strobe |
| clrTimerPulse | output | 1 | Clear-timer strobe |
| abortPulse | output | 1 | Frame abort strobe |
| rxLevel | output | CNT_W | Receive FIFO level |
| rxStatus | output | STAT_W | Receive status, bit 0 enable |
| rxOwnFlags | output | 2 | Receive buffer ownership A/B |
| rxHunting | output | 1 | Receiver in sync/flag hunt |
| txLevel | output | CNT_W | Transmit FIFO level |
| txStatus | output | STAT_W | Transmit status, bit 0 enable |
| txOwnFlags | output | 2 | Transmit buffer ownership A/B |
| bufStatus | output | 4 | Combined buffer status, rx 1:0, tx 3:2 |
| timer2Val | output | TIMER_W | General timer value |
| txLine | output | 1 | Serial line level |
| txAborting | output | 1 | Abort ones being sent |

## Verification
The bench builds the block with DEPTH=8, TIMER_W=4 and ABORT_ONES=9. A shallow FIFO lets pushes reach the saturation point quickly, so R13 is exercised many times over. A four-bit timer wraps every sixteen ticks, so clears land both before and after a wrap. An abort length above the minimum of seven shows that the ones window follows the parameter rather than a fixed count.

// File: rtl/chanCmdPkg.sv
package chanCmdPkg;

  typedef struct packed {
    logic clrRx;
    logic clrTx;
    logic clrTimer;
    logic abortTx;
  } cmdStrobe_t;

  localparam int CH_CLR_TIMER = 5;
  localparam int CH_CLR_RX    = 4;
  localparam int CH_CLR_TX    = 3;
  localparam logic [7:0] CH_MASK = 8'h38;

  localparam int TX_ABORT = 6;
  localparam logic [7:0] TX_MASK = 8'h6F;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;

endpackage

// File: rtl/chanCmdCtl.sv
module chanCmdCtl
  import chanCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       cmdSel,
  input  logic [7:0] cmdData,
  input  logic       asyncMode,
  output logic [7:0] chanReg,
  output logic [7:0] txReg,
  output cmdStrobe_t strobe
);

  // A register holds a write for one cycle; acceptance returns it to zero.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanReg <= '0;
      txReg   <= '0;
    end else begin
      chanReg <= (cmdWr && !cmdSel) ? (cmdData & CH_MASK) : 8'h00;
      txReg   <= (cmdWr &&  cmdSel) ? (cmdData & TX_MASK) : 8'h00;
    end
  end

  always_comb begin
    strobe.clrRx    = chanReg[CH_CLR_RX];
    strobe.clrTx    = chanReg[CH_CLR_TX] & asyncMode;
    strobe.clrTimer = chanReg[CH_CLR_TIMER];
    strobe.abortTx  = txReg[TX_ABORT] & ~asyncMode;
  end

endmodule

// File: rtl/chanSideState.sv
module chanSideState #(
  parameter int STAT_W = 8,
  parameter int OWN_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic [STAT_W-1:0] statSet,
  input  logic [OWN_N-1:0]  bufGive,
  output logic [STAT_W-1:0] status,
  output logic [OWN_N-1:0]  own
);

  localparam logic [STAT_W-1:0] KEEP_MASK = STAT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      own    <= '0;
    end else if (clear) begin
      status <= (status | statSet) & KEEP_MASK;
      own    <= '0;
    end else begin
      status <= status | statSet;
      own    <= own | bufGive;
    end
  end

endmodule

// File: rtl/chanLineGen.sv
module chanLineGen
  import chanCmdPkg::*;
#(
  parameter int ABORT_ONES = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncMode,
  input  logic abortTx,
  output logic txLine,
  output logic txAborting
);

  localparam int LEFT_W = $clog2(ABORT_ONES + 1);

  logic [LEFT_W-1:0] onesLeft;
  logic [2:0]        flagIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLine     <= 1'b1;
      txAborting <= 1'b0;
      onesLeft   <= '0;
      flagIdx    <= '0;
    end else if (abortTx) begin
      txLine     <= 1'b1;
      txAborting <= 1'b1;
      onesLeft   <= LEFT_W'(ABORT_ONES - 1);
      flagIdx    <= '0;
    end else if (onesLeft != '0) begin
      txLine     <= 1'b1;
      txAborting <= 1'b1;
      onesLeft   <= onesLeft - 1'b1;
    end else begin
      txAborting <= 1'b0;
      if (asyncMode) begin
        txLine  <= 1'b1;
        flagIdx <= '0;
      end else begin
        txLine  <= FLAG_PATTERN[flagIdx];
        flagIdx <= flagIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/chanStubPath.sv
module chanStubPath
  import chanCmdPkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int STAT_W  = 8,
  parameter int TIMER_W = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmdStrobe_t         strobe,
  input  logic               asyncMode,
  input  logic               dmaMode,
  input  logic               rxPush,
  input  logic [STAT_W-1:0]  rxStatSet,
  input  logic [1:0]         rxBufGive,
  input  logic               rxSyncFound,
  input  logic               txPush,
  input  logic               txPushEof,
  input  logic [STAT_W-1:0]  txStatSet,
  input  logic [1:0]         txBufGive,
  input  logic [3:0]         bufStatSet,
  input  logic               timerTick,
  output logic [CNT_W-1:0]   rxLevel,
  output logic [STAT_W-1:0]  rxStatus,
  output logic [1:0]         rxOwnFlags,
  output logic               rxHunting,
  output logic [CNT_W-1:0]   txLevel,
  output logic [STAT_W-1:0]  txStatus,
  output logic [1:0]         txOwnFlags,
  output logic [3:0]         bufStatus,
  output logic [TIMER_W-1:0] timer2Val
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam int SIDES = 2;

  // Side 0 is receive, side 1 is transmit; both keep the same shape.
  logic [SIDES-1:0]             sideClear;
  logic [SIDES-1:0][STAT_W-1:0] sideSet;
  logic [SIDES-1:0][1:0]        sideGive;
  logic [SIDES-1:0][STAT_W-1:0] sideStat;
  logic [SIDES-1:0][1:0]        sideOwn;

  assign sideClear = {strobe.clrTx, strobe.clrRx};
  assign sideSet   = {txStatSet, rxStatSet};
  assign sideGive  = {txBufGive, rxBufGive};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    chanSideState #(.STAT_W(STAT_W), .OWN_N(2)) side_i (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (sideClear[s]),
      .statSet (sideSet[s]),
      .bufGive (sideGive[s]),
      .status  (sideStat[s]),
      .own     (sideOwn[s])
    );
  end

  assign rxStatus   = sideStat[0];
  assign txStatus   = sideStat[1];
  assign rxOwnFlags = sideOwn[0];
  assign txOwnFlags = sideOwn[1];

  // Receive FIFO level: pushes need a buffer owned by the device.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxLevel <= '0;
    end else if (strobe.clrRx) begin
      rxLevel <= '0;
    end else if (rxPush && (rxOwnFlags != 2'b00) && (rxLevel < FULL)) begin
      rxLevel <= rxLevel + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHunting <= 1'b1;
    end else if (strobe.clrRx && !asyncMode) begin
      rxHunting <= 1'b1;
    end else if (rxSyncFound) begin
      rxHunting <= 1'b0;
    end
  end

  // Transmit FIFO level with the distance to the first end-of-frame entry.
  logic [CNT_W-1:0] toEof;
  logic             eofSeen;
  logic [CNT_W-1:0] keptLevel;

  assign keptLevel = eofSeen ? (txLevel - toEof) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLevel <= '0;
      toEof   <= '0;
      eofSeen <= 1'b0;
    end else if (strobe.clrTx) begin
      txLevel <= '0;
      toEof   <= '0;
      eofSeen <= 1'b0;
    end else if (strobe.abortTx && dmaMode) begin
      txLevel <= keptLevel;
      toEof   <= keptLevel;
      eofSeen <= 1'b0;
    end else if (txPush && (txLevel < FULL)) begin
      txLevel <= txLevel + 1'b1;
      if (!eofSeen) begin
        toEof   <= toEof + 1'b1;
        eofSeen <= txPushEof;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufStatus <= '0;
    end else begin
      bufStatus <= (bufStatus | bufStatSet)
                 & {{2{~strobe.clrTx}}, {2{~strobe.clrRx}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer2Val <= '0;
    end else if (strobe.clrTimer) begin
      timer2Val <= '0;
    end else if (timerTick) begin
      timer2Val <= timer2Val + 1'b1;
    end
  end

endmodule

// File: rtl/chanCmdExec.sv
module chanCmdExec
  import chanCmdPkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int STAT_W     = 8,
  parameter int TIMER_W    = 16,
  parameter int ABORT_ONES = 7,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWr,
  input  logic               cmdSel,
  input  logic [7:0]         cmdData,
  input  logic               asyncMode,
  input  logic               dmaMode,
  input  logic               rxPush,
  input  logic [STAT_W-1:0]  rxStatSet,
  input  logic [1:0]         rxBufGive,
  input  logic               rxSyncFound,
  input  logic               txPush,
  input  logic               txPushEof,
  input  logic [STAT_W-1:0]  txStatSet,
  input  logic [1:0]         txBufGive,
  input  logic [3:0]         bufStatSet,
  input  logic               timerTick,
  output logic [7:0]         chanCmdRd,
  output logic [7:0]         txCmdRd,
  output logic               clrRxPulse,
  output logic               clrTxPulse,
  output logic               clrTimerPulse,
  output logic               abortPulse,
  output logic [CNT_W-1:0]   rxLevel,
  output logic [STAT_W-1:0]  rxStatus,
  output logic [1:0]         rxOwnFlags,
  output logic               rxHunting,
  output logic [CNT_W-1:0]   txLevel,
  output logic [STAT_W-1:0]  txStatus,
  output logic [1:0]         txOwnFlags,
  output logic [3:0]         bufStatus,
  output logic [TIMER_W-1:0] timer2Val,
  output logic               txLine,
  output logic               txAborting
);

  cmdStrobe_t strobe;

  chanCmdCtl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWr     (cmdWr),
    .cmdSel    (cmdSel),
    .cmdData   (cmdData),
    .asyncMode (asyncMode),
    .chanReg   (chanCmdRd),
    .txReg     (txCmdRd),
    .strobe    (strobe)
  );

  chanStubPath #(.DEPTH(DEPTH), .STAT_W(STAT_W), .TIMER_W(TIMER_W)) path_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .asyncMode   (asyncMode),
    .dmaMode     (dmaMode),
    .rxPush      (rxPush),
    .rxStatSet   (rxStatSet),
    .rxBufGive   (rxBufGive),
    .rxSyncFound (rxSyncFound),
    .txPush      (txPush),
    .txPushEof   (txPushEof),
    .txStatSet   (txStatSet),
    .txBufGive   (txBufGive),
    .bufStatSet  (bufStatSet),
    .timerTick   (timerTick),
    .rxLevel     (rxLevel),
    .rxStatus    (rxStatus),
    .rxOwnFlags  (rxOwnFlags),
    .rxHunting   (rxHunting),
    .txLevel     (txLevel),
    .txStatus    (txStatus),
    .txOwnFlags  (txOwnFlags),
    .bufStatus   (bufStatus),
    .timer2Val   (timer2Val)
  );

  chanLineGen #(.ABORT_ONES(ABORT_ONES)) line_i (
    .clk        (clk),
    .rstN       (rstN),
    .asyncMode  (asyncMode),
    .abortTx    (strobe.abortTx),
    .txLine     (txLine),
    .txAborting (txAborting)
  );

  assign clrRxPulse    = strobe.clrRx;
  assign clrTxPulse    = strobe.clrTx;
  assign clrTimerPulse = strobe.clrTimer;
  assign abortPulse    = strobe.abortTx;

endmodule

// File: rtl/chanCmdExec_chk.sv
module chanCmdExec_chk #(
  parameter int DEPTH      = 16,
  parameter int STAT_W     = 8,
  parameter int TIMER_W    = 16,
  parameter int ABORT_ONES = 7,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdWr,
  input logic               cmdSel,
  input logic [7:0]         cmdData,
  input logic               asyncMode,
  input logic               dmaMode,
  input logic               rxPush,
  input logic [STAT_W-1:0]  rxStatSet,
  input logic [1:0]         rxBufGive,
  input logic               rxSyncFound,
  input logic               txPush,
  input logic               txPushEof,
  input logic [STAT_W-1:0]  txStatSet,
  input logic [1:0]         txBufGive,
  input logic [3:0]         bufStatSet,
  input logic               timerTick,
  input logic [7:0]         chanCmdRd,
  input logic [7:0]         txCmdRd,
  input logic               clrRxPulse,
  input logic               clrTxPulse,
  input logic               clrTimerPulse,
  input logic               abortPulse,
  input logic [CNT_W-1:0]   rxLevel,
  input logic [STAT_W-1:0]  rxStatus,
  input logic [1:0]         rxOwnFlags,
  input logic               rxHunting,
  input logic [CNT_W-1:0]   txLevel,
  input logic [STAT_W-1:0]  txStatus,
  input logic [1:0]         txOwnFlags,
  input logic [3:0]         bufStatus,
  input logic [TIMER_W-1:0] timer2Val,
  input logic               txLine,
  input logic               txAborting
);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdRd[7] == 1'b0) && (txCmdRd[4] == 1'b0));

  p_self_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmdWr) |-> (chanCmdRd == 8'h00) && (txCmdRd == 8'h00));

  p_rx_pulse_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    clrRxPulse |-> $past(cmdWr) && !$past(cmdSel));

  p_rx_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    clrRxPulse |=> (rxLevel == '0) && (rxStatus[STAT_W-1:1] == '0));

  p_rx_own_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrRxPulse |=> (rxOwnFlags == 2'b00) && (bufStatus[1:0] == 2'b00));

  p_hunt_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrRxPulse && !asyncMode |=> rxHunting);

  p_tx_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrTxPulse |=> (txLevel == '0) && (txOwnFlags == 2'b00) && (bufStatus[3:2] == 2'b00));

  p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrTxPulse |-> asyncMode);

  p_timer_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrTimerPulse |=> (timer2Val == '0));

  p_abort_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !asyncMode);

  p_abort_line_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> txLine && txAborting);

  p_rx_owned_push_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel > $past(rxLevel)) |-> ($past(rxOwnFlags) != 2'b00));

  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= CNT_W'(DEPTH)) && (txLevel <= CNT_W'(DEPTH)));

endmodule

bind chanCmdExec chanCmdExec_chk #(
  .DEPTH(DEPTH), .STAT_W(STAT_W), .TIMER_W(TIMER_W), .ABORT_ONES(ABORT_ONES)
) chk_i (.*);

// File: tb/chanCmdExec_tb_top.sv
module chanCmdExec_tb_top;

  localparam int DEPTH = 8;
  localparam int SW    = 8;
  localparam int TW    = 4;
  localparam int AONES = 9;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 0, cmdSel = 0, asyncMode = 1, dmaMode = 0;
  logic [7:0] cmdData = '0;
  logic rxPush = 0, rxSyncFound = 0, txPush = 0, txPushEof = 0, timerTick = 0;
  logic [SW-1:0] rxStatSet = '0, txStatSet = '0;
  logic [1:0] rxBufGive = '0, txBufGive = '0;
  logic [3:0] bufStatSet = '0;

  logic [7:0] chanCmdRd, txCmdRd;
  logic clrRxPulse, clrTxPulse, clrTimerPulse, abortPulse;
  logic [CW-1:0] rxLevel, txLevel;
  logic [SW-1:0] rxStatus, txStatus;
  logic [1:0] rxOwnFlags, txOwnFlags;
  logic rxHunting, txLine, txAborting;
  logic [3:0] bufStatus;
  logic [TW-1:0] timer2Val;

  chanCmdExec #(.DEPTH(DEPTH), .STAT_W(SW), .TIMER_W(TW), .ABORT_ONES(AONES)) dut_i (.*);

  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  // Reference model state
  logic [7:0] mChan, mTx;
  int mRxLvl, mTxLvl, mToEof, mTimer;
  logic mEofSeen, mHunt;
  logic [SW-1:0] mRxStat, mTxStat;
  logic [1:0] mRxOwn, mTxOwn;
  logic [3:0] mBuf;

  function automatic logic expRxP(); return mChan[4]; endfunction
  function automatic logic expTxP(); return mChan[3] & asyncMode; endfunction
  function automatic logic expTmP(); return mChan[5]; endfunction
  function automatic logic expAbP(); return mTx[6] & ~asyncMode; endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mChan = 0; mTx = 0; mRxLvl = 0; mTxLvl = 0; mToEof = 0; mTimer = 0;
    mEofSeen = 0; mHunt = 1; mRxStat = 0; mTxStat = 0;
    mRxOwn = 0; mTxOwn = 0; mBuf = 0;
  endtask

  task automatic modelStep();
    logic pRx, pTx, pTm, pAb;
    int kept;
    pRx = expRxP(); pTx = expTxP(); pTm = expTmP(); pAb = expAbP();
    // receive side
    if (pRx) mRxLvl = 0;
    else if (rxPush && mRxOwn != 0 && mRxLvl < DEPTH) mRxLvl++;
    if (pRx) begin mRxStat = {{(SW-1){1'b0}}, mRxStat[0] | rxStatSet[0]}; mRxOwn = 0; end
    else begin mRxStat = mRxStat | rxStatSet; mRxOwn = mRxOwn | rxBufGive; end
    if (pRx && !asyncMode) mHunt = 1;
    else if (rxSyncFound) mHunt = 0;
    // transmit side
    if (pTx) begin mTxLvl = 0; mToEof = 0; mEofSeen = 0; end
    else if (pAb && dmaMode) begin
      kept = mEofSeen ? (mTxLvl - mToEof) : 0;
      mTxLvl = kept; mToEof = kept; mEofSeen = 0;
    end else if (txPush && mTxLvl < DEPTH) begin
      mTxLvl++;
      if (!mEofSeen) begin mToEof++; mEofSeen = txPushEof; end
    end
    if (pTx) begin mTxStat = {{(SW-1){1'b0}}, mTxStat[0] | txStatSet[0]}; mTxOwn = 0; end
    else begin mTxStat = mTxStat | txStatSet; mTxOwn = mTxOwn | txBufGive; end
    mBuf = mBuf | bufStatSet;
    if (pRx) mBuf[1:0] = 0;
    if (pTx) mBuf[3:2] = 0;
    if (pTm) mTimer = 0; else if (timerTick) mTimer = (mTimer + 1) % (1 << TW);
    // command registers
    mChan = (cmdWr && !cmdSel) ? (cmdData & 8'h38) : 8'h00;
    mTx   = (cmdWr &&  cmdSel) ? (cmdData & 8'h6F) : 8'h00;
  endtask

  task automatic compareAll();
    chk("R2 chanCmdRd", chanCmdRd, mChan);
    chk("R2 txCmdRd", txCmdRd, mTx);
    chk("R3 clrRxPulse", clrRxPulse, expRxP());
    chk("R8 clrTxPulse", clrTxPulse, expTxP());
    chk("R9 clrTimerPulse", clrTimerPulse, expTmP());
    chk("R10 abortPulse", abortPulse, expAbP());
    chk("R4 R12 R13 rxLevel", rxLevel, mRxLvl);
    chk("R4 rxStatus", rxStatus, mRxStat);
    chk("R5 rxOwnFlags", rxOwnFlags, mRxOwn);
    chk("R6 rxHunting", rxHunting, mHunt);
    chk("R7 R11 txLevel", txLevel, mTxLvl);
    chk("R7 txStatus", txStatus, mTxStat);
    chk("R7 txOwnFlags", txOwnFlags, mTxOwn);
    chk("R5 R7 bufStatus", bufStatus, mBuf);
    chk("R9 timer2Val", timer2Val, mTimer);
  endtask

  task automatic clearIns();
    cmdWr = 0; cmdSel = 0; cmdData = 0; rxPush = 0; rxStatSet = 0; rxBufGive = 0;
    rxSyncFound = 0; txPush = 0; txPushEof = 0; txStatSet = 0; txBufGive = 0;
    bufStatSet = 0; timerTick = 0;
  endtask

  // Inputs are set after a falling edge; compare, clock, update model.
  task automatic step();
    #2 compareAll();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    clearIns();
  endtask

  task automatic writeCmd(input logic sel, input logic [7:0] d);
    cmdWr = 1; cmdSel = sel; cmdData = d;
    step();
  endtask

  initial begin
    #(20 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #2 chk("R1 rxHunting", rxHunting, 1);
    chk("R1 txLine", txLine, 1);
    chk("R1 txCmdRd", txCmdRd, 0);
    compareAll();

    // R2 reserved bits and self clear
    writeCmd(1, 8'hFF);
    chk("R2 txCmdRd masked", txCmdRd, 8'h6F);
    step();
    chk("R2 txCmdRd cleared", txCmdRd, 0);

    // R3 several bits together in async mode
    asyncMode = 1;
    writeCmd(0, 8'hFF);
    chk("R3 chanCmdRd", chanCmdRd, 8'h38);
    chk("R3 all strobes", {clrRxPulse, clrTxPulse, clrTimerPulse}, 3'b111);
    step();
    chk("R3 strobes single cycle", {clrRxPulse, clrTxPulse, clrTimerPulse}, 3'b000);

    // R12 push without ownership is dropped, R13 saturation
    rxPush = 1; step();
    chk("R12 rxLevel no buffer", rxLevel, 0);
    rxBufGive = 2'b01; step();
    for (int i = 0; i < DEPTH + 3; i++) begin rxPush = 1; step(); end
    chk("R13 rxLevel saturates", rxLevel, DEPTH);

    // R8 clear transmitter ignored in synchronous mode
    asyncMode = 0;
    for (int i = 0; i < 3; i++) begin txPush = 1; step(); end
    writeCmd(0, 8'h08);
    chk("R8 no clrTx strobe", clrTxPulse, 0);
    step();
    chk("R8 txLevel kept", txLevel, 3);

    // R10 abort sequence on the line
    writeCmd(1, 8'h40);
    chk("R10 abort strobe", abortPulse, 1);
    step();
    chk("R10 txAborting", txAborting, 1);
    for (int i = 0; i < AONES; i++) begin
      chk("R10 abort one", txLine, 1);
      step();
    end
    chk("R10 aborting ends", txAborting, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R10 flag bit", txLine, (i == 0 || i == 7) ? 0 : 1);
      step();
    end

    // R11 abort with DMA drops through first end-of-frame
    asyncMode = 1; writeCmd(0, 8'h08); step();
    chk("R7 txLevel cleared", txLevel, 0);
    asyncMode = 0; dmaMode = 1;
    for (int i = 0; i < 6; i++) begin
      txPush = 1; txPushEof = (i == 3); step();
    end
    writeCmd(1, 8'h40); step();
    chk("R11 dropped to eof", txLevel, 2);
    dmaMode = 0;
    writeCmd(1, 8'h40); step();
    chk("R11 no drop without dma", txLevel, 2);
    repeat (AONES + 2) step();

    // R10 abort ignored in async mode
    asyncMode = 1;
    repeat (2) step();
    writeCmd(1, 8'h40);
    chk("R10 async abort ignored", abortPulse, 0);
    step();
    chk("R10 async line idle", txLine, 1);

    // Constrained random mix checked against the model
    for (int n = 0; n < 4000; n++) begin
      cmdWr = ($urandom % 4) == 0;
      cmdSel = $urandom % 2;
      cmdData = 8'($urandom);
      rxPush = $urandom % 2;
      rxStatSet = (($urandom % 8) == 0) ? SW'($urandom) : '0;
      rxBufGive = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
      rxSyncFound = ($urandom % 8) == 0;
      txPush = $urandom % 2;
      txPushEof = ($urandom % 4) == 0;
      txStatSet = (($urandom % 8) == 0) ? SW'($urandom) : '0;
      txBufGive = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
      bufStatSet = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
      timerTick = $urandom % 2;
      dmaMode = $urandom % 2;
      if (($urandom % 32) == 0) asyncMode = ~asyncMode;
      step();
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule